// File: doc/BRIEF.md
# Masked Multiplicity Coincidence Trigger

This block turns 48 fast trigger lines into a set of coincidence triggers. The lines come from three 16-line buses: the module's own channels, the neighbour module on the left and the neighbour module on the right. Every group owns a 48-bit enable mask over those lines and one 3-bit threshold for each bus section. In each section the group counts the lines that are both enabled and active. The section passes when that count reaches its threshold. The group fires when all three sections pass.

Alongside the counting, each group holds three 4-bit line indices. Each index picks one raw line out of the local, left or right bus. A module at the end of a crate has no neighbour on one side, so a presence input per side forces that bus inactive. Configuration arrives as flat parallel vectors. All outputs are registered and appear one clock after the inputs that cause them.

Top module: `coinc_mult_trigger`

## Requirements
- R1: Line k of the 48-line vector is local_trig[k] for k in 0..15, left_trig[k-16] for k in 16..31 and right_trig[k-32] for k in 32..47. Bit k of a group's mask (group g occupies grp_mask[g*48 +: 48]) enables line k.
- R2: A line whose mask bit is 0 never adds to a count. With an all-zero mask and any nonzero threshold field, the group output is 0.
- R3: For each section, the count is the number of lines that are both active and enabled. The section condition is true when that count is greater than or equal to the section's threshold (0 to 7).
- R4: coinc_out[g] is the AND of the three section conditions of group g.
- R5: The threshold of group g is grp_thresh[g*9 +: 9]: local in bits [2:0], left in [5:3], right in [8:6]. A threshold of 0 makes its section condition true for every input.
- R6: When left_present is 0, the left bus counts as all inactive for both counting and selection. right_present does the same for the right bus.
- R7: The indices of group g are grp_index[g*12 +: 12]: local in [3:0], left in [7:4], right in [11:8]. pick_out[g*3+0], [g*3+1] and [g*3+2] carry the indexed local, left and right line. The mask does not affect selection.
- R8: coinc_out and pick_out are registered. They reflect the inputs present at the previous rising clock edge.
- R9: While rst is high at a clock edge, all outputs are cleared to 0.
- R10: Each group uses only its own mask, thresholds and indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_trig | input | 16 | Fast triggers of this module's channels |
| left_trig | input | 16 | Fast triggers from the left neighbour |
| right_trig | input | 16 | Fast triggers from the right neighbour |
| left_present | input | 1 | 1 when a left neighbour exists |
| right_present | input | 1 | 1 when a right neighbour exists |
| grp_mask | input | 768 | 48-bit line enable mask per group |
| grp_thresh | input | 144 | Three 3-bit thresholds per group |
| grp_index | input | 192 | Three 4-bit line indices per group |
| coinc_out | output | 16 | Registered coincidence result per group |
| pick_out | output | 48 | Registered selected lines, three per group |

## Verification
The assertions assume that the trigger lines, presence flags and configuration vectors are valid, non-X levels sampled at the clock edge. They also assume that configuration may change on any cycle, with no settling window. The bench drives every input on the falling edge, so each value is stable across the rising edge that captures it. The bench holds every input at defined zeros from time zero, so the one-cycle lookback after reset sees known values.

// File: rtl/coinc_trig_pkg.sv
package coinc_trig_pkg;

    // Number of bus sections feeding the counter: local, left, right.
    localparam int NUM_SECT = 3;

    // Section ordering inside the concatenated line vector.
    localparam int SECT_LOC   = 0;
    localparam int SECT_LEFT  = 1;
    localparam int SECT_RIGHT = 2;

    typedef enum logic [1:0] {
        SRC_LOC   = 2'd0,
        SRC_LEFT  = 2'd1,
        SRC_RIGHT = 2'd2
    } src_e;

    // Lowest line number of a section.
    function automatic int sect_lo(input int sect, input int lines_per_sect);
        return sect * lines_per_sect;
    endfunction

    // Width needed to hold a value up to n (at least 1 bit).
    function automatic int width_for(input int n);
        int w;
        w = 1;
        while ((1 << w) <= n) w++;
        return w;
    endfunction

endpackage

// File: rtl/coinc_edge_gate.sv
module coinc_edge_gate
    import coinc_trig_pkg::*;
#(
    parameter int SECT_LINES = 16,
    localparam int LINES     = NUM_SECT * SECT_LINES
)(
    input  logic [SECT_LINES-1:0] local_trig,
    input  logic [SECT_LINES-1:0] left_trig,
    input  logic [SECT_LINES-1:0] right_trig,
    input  logic                  left_present,
    input  logic                  right_present,
    output logic [LINES-1:0]      lines
);

    // Missing neighbours contribute inactive lines.
    always_comb begin
        lines = '0;
        lines[sect_lo(SECT_LOC,   SECT_LINES) +: SECT_LINES] = local_trig;
        lines[sect_lo(SECT_LEFT,  SECT_LINES) +: SECT_LINES] =
            left_present  ? left_trig  : '0;
        lines[sect_lo(SECT_RIGHT, SECT_LINES) +: SECT_LINES] =
            right_present ? right_trig : '0;
    end

endmodule

// File: rtl/coinc_sect_count.sv
module coinc_sect_count
    import coinc_trig_pkg::*;
#(
    parameter int SECT_LINES = 16,
    parameter int THR_W      = 3,
    localparam int CNT_W     = width_for(SECT_LINES),
    localparam int CMP_W     = (CNT_W > THR_W) ? CNT_W : THR_W
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SECT_LINES-1:0] lines,
    input  logic [SECT_LINES-1:0] mask,
    input  logic [THR_W-1:0]      thr,
    output logic                  ok
);

    logic [CNT_W-1:0] cnt;

    // Population count of the enabled, active lines.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < SECT_LINES; i++) begin
            cnt = cnt + CNT_W'(lines[i] & mask[i]);
        end
    end

    always_comb begin
        ok = (CMP_W'(cnt) >= CMP_W'(thr));
    end

    // R3: masking can only lower the count below the raw active count.
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= $countones(lines));

endmodule

// File: rtl/coinc_group.sv
module coinc_group
    import coinc_trig_pkg::*;
#(
    parameter int SECT_LINES = 16,
    parameter int THR_W      = 3,
    localparam int LINES     = NUM_SECT * SECT_LINES,
    localparam int IDX_W     = width_for(SECT_LINES - 1)
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LINES-1:0]          lines,
    input  logic [LINES-1:0]          mask,
    input  logic [NUM_SECT*THR_W-1:0] thr,
    input  logic [NUM_SECT*IDX_W-1:0] idx,
    output logic                      coinc_q,
    output logic [NUM_SECT-1:0]       pick_q
);

    logic [NUM_SECT-1:0] sect_ok;
    logic [NUM_SECT-1:0] pick_d;

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        logic [SECT_LINES-1:0] sect_lines;
        logic [IDX_W-1:0]      sel;

        assign sect_lines = lines[sect_lo(s, SECT_LINES) +: SECT_LINES];
        assign sel        = idx[s*IDX_W +: IDX_W];

        coinc_sect_count #(
            .SECT_LINES (SECT_LINES),
            .THR_W      (THR_W)
        ) u_count (
            .clk   (clk),
            .rst   (rst),
            .lines (sect_lines),
            .mask  (mask[sect_lo(s, SECT_LINES) +: SECT_LINES]),
            .thr   (thr[s*THR_W +: THR_W]),
            .ok    (sect_ok[s])
        );

        // Single-line selection ignores the mask.
        assign pick_d[s] = sect_lines[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coinc_q <= 1'b0;
            pick_q  <= '0;
        end else begin
            coinc_q <= &sect_ok;
            pick_q  <= pick_d;
        end
    end

    // R2: nothing enabled and some threshold above zero means no trigger.
    assert_empty_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (mask == '0 && thr != '0) |=> !coinc_q);

    // R5: all thresholds zero always fires.
    assert_zero_thr_R5: assert property (@(posedge clk) disable iff (rst)
        (thr == '0) |=> coinc_q);

    // R4: any failing section blocks the group.
    assert_and_sections_R4: assert property (@(posedge clk) disable iff (rst)
        (sect_ok != '1) |=> !coinc_q);

endmodule

// File: rtl/coinc_mult_trigger.sv
module coinc_mult_trigger
    import coinc_trig_pkg::*;
#(
    parameter int NUM_GROUPS = 16,
    parameter int SECT_LINES = 16,
    parameter int THR_W      = 3,
    localparam int LINES     = NUM_SECT * SECT_LINES,
    localparam int IDX_W     = width_for(SECT_LINES - 1),
    localparam int GT_W      = NUM_SECT * THR_W,
    localparam int GI_W      = NUM_SECT * IDX_W
)(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [SECT_LINES-1:0]          local_trig,
    input  logic [SECT_LINES-1:0]          left_trig,
    input  logic [SECT_LINES-1:0]          right_trig,
    input  logic                           left_present,
    input  logic                           right_present,
    input  logic [NUM_GROUPS*LINES-1:0]    grp_mask,
    input  logic [NUM_GROUPS*GT_W-1:0]     grp_thresh,
    input  logic [NUM_GROUPS*GI_W-1:0]     grp_index,
    output logic [NUM_GROUPS-1:0]          coinc_out,
    output logic [NUM_GROUPS*NUM_SECT-1:0] pick_out
);

    logic [LINES-1:0] lines;

    coinc_edge_gate #(
        .SECT_LINES (SECT_LINES)
    ) u_gate (
        .local_trig    (local_trig),
        .left_trig     (left_trig),
        .right_trig    (right_trig),
        .left_present  (left_present),
        .right_present (right_present),
        .lines         (lines)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        coinc_group #(
            .SECT_LINES (SECT_LINES),
            .THR_W      (THR_W)
        ) u_group (
            .clk     (clk),
            .rst     (rst),
            .lines   (lines),
            .mask    (grp_mask[g*LINES +: LINES]),
            .thr     (grp_thresh[g*GT_W +: GT_W]),
            .idx     (grp_index[g*GI_W +: GI_W]),
            .coinc_q (coinc_out[g]),
            .pick_q  (pick_out[g*NUM_SECT +: NUM_SECT])
        );

        // R6: an absent neighbour never shows up on a selected line.
        assert_no_left_R6: assert property (@(posedge clk) disable iff (rst)
            !left_present |=> !pick_out[g*NUM_SECT + SECT_LEFT]);
        assert_no_right_R6: assert property (@(posedge clk) disable iff (rst)
            !right_present |=> !pick_out[g*NUM_SECT + SECT_RIGHT]);
    end

endmodule

// File: tb/coinc_mult_trigger_test.sv
`timescale 1ns/100ps
module coinc_mult_trigger_test;

    localparam int G = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  local_trig = '0, left_trig = '0, right_trig = '0;
    logic         left_present = 1'b0, right_present = 1'b0;
    logic [767:0] grp_mask = '0;
    logic [143:0] grp_thresh = '0;
    logic [191:0] grp_index = '0;
    logic [15:0]  coinc_out;
    logic [47:0]  pick_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    coinc_mult_trigger uut (
        .clk(clk), .rst(rst),
        .local_trig(local_trig), .left_trig(left_trig), .right_trig(right_trig),
        .left_present(left_present), .right_present(right_present),
        .grp_mask(grp_mask), .grp_thresh(grp_thresh), .grp_index(grp_index),
        .coinc_out(coinc_out), .pick_out(pick_out)
    );

    typedef struct packed {
        logic [15:0] loc;
        logic [15:0] lft;
        logic [15:0] rgt;
        logic        lp;
        logic        rp;
        logic [47:0] mask;
        logic [8:0]  thr;   // {right, left, local}
        logic [11:0] idx;   // {right, left, local}
        logic        exp_c;
        logic [2:0]  exp_p; // {right, left, local}
    } vec_t;

    localparam logic [47:0] ALL = {48{1'b1}};

    localparam vec_t TBL [10] = '{
        // R3: no activity, threshold 1 everywhere
        '{16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1, ALL, {3'd1,3'd1,3'd1}, 12'h000, 1'b0, 3'b000},
        // R4/R7: every section meets its threshold
        '{16'h0003, 16'h0001, 16'h8000, 1'b1, 1'b1, ALL, {3'd1,3'd1,3'd2}, 12'hF01, 1'b1, 3'b111},
        // R3: local count 2 below 3
        '{16'h0003, 16'h0001, 16'h8000, 1'b1, 1'b1, ALL, {3'd1,3'd1,3'd3}, 12'hF01, 1'b0, 3'b111},
        // R2: local line 0 masked off; R7 selection ignores mask
        '{16'h0003, 16'h0001, 16'h8000, 1'b1, 1'b1, {32'hFFFF_FFFF,16'hFFFE}, {3'd1,3'd1,3'd2}, 12'hF01, 1'b0, 3'b111},
        // R5: zero thresholds with no activity
        '{16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1, ALL, 9'd0, 12'h000, 1'b1, 3'b000},
        // R6: left absent
        '{16'h0000, 16'hFFFF, 16'h0000, 1'b0, 1'b1, ALL, {3'd0,3'd1,3'd0}, 12'h050, 1'b0, 3'b000},
        // R6: right absent
        '{16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b0, ALL, {3'd1,3'd0,3'd0}, 12'h300, 1'b0, 3'b000},
        // R3: threshold 7 and exact threshold 4 met
        '{16'h0000, 16'h00F0, 16'hFFFF, 1'b1, 1'b1, ALL, {3'd7,3'd4,3'd0}, 12'h040, 1'b1, 3'b110},
        // R3: left count 3 below 4
        '{16'h0000, 16'h0070, 16'hFFFF, 1'b1, 1'b1, ALL, {3'd7,3'd4,3'd0}, 12'h040, 1'b0, 3'b110},
        // R2: empty mask with all lines active
        '{16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 48'd0, {3'd1,3'd0,3'd0}, 12'hFFF, 1'b0, 3'b111}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Group 0 gets the row; other groups get mask 0, local threshold 1.
    task automatic apply(input vec_t v);
        local_trig    = v.loc;
        left_trig     = v.lft;
        right_trig    = v.rgt;
        left_present  = v.lp;
        right_present = v.rp;
        for (int g = 0; g < G; g++) begin
            grp_mask[g*48 +: 48]  = (g == 0) ? v.mask : 48'd0;
            grp_thresh[g*9 +: 9]  = (g == 0) ? v.thr  : 9'd1;
            grp_index[g*12 +: 12] = (g == 0) ? v.idx  : 12'd0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        vec_t v;
        // R9: reset holds outputs low even with a zero-threshold group.
        left_present  = 1'b1;
        right_present = 1'b1;
        local_trig    = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk("R9 reset coinc", 64'(coinc_out), 64'd0);
        chk("R9 reset pick", 64'(pick_out), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R5 zero thresholds after reset", 64'(coinc_out), 64'hFFFF);

        // Table walk: drive on falling edge, sample one cycle later (R8).
        for (int i = 0; i < 10; i++) begin
            apply(TBL[i]);
            @(negedge clk);
            chk($sformatf("R1/R3 row %0d coinc", i), 64'(coinc_out), 64'(TBL[i].exp_c));
            chk($sformatf("R7 row %0d pick", i), 64'(pick_out[2:0]), 64'(TBL[i].exp_p));
        end

        // R8: one cycle latency, output holds until the next rising edge.
        apply(TBL[1]);
        @(negedge clk);
        apply(TBL[2]);
        #1;
        chk("R8 output holds before edge", 64'(coinc_out[0]), 64'd1);
        @(negedge clk);
        chk("R8 output updates after edge", 64'(coinc_out[0]), 64'd0);

        // R10: two groups with different settings on the same lines.
        v = TBL[0];
        v.loc  = 16'h0007;
        v.mask = ALL;
        v.thr  = {3'd0, 3'd0, 3'd4};
        v.idx  = 12'h000;
        apply(v);
        grp_mask[7*48 +: 48]  = ALL;
        grp_thresh[7*9 +: 9]  = {3'd0, 3'd0, 3'd3};
        grp_index[7*12 +: 12] = 12'h002;
        @(negedge clk);
        chk("R10 group 0 below threshold", 64'(coinc_out[0]), 64'd0);
        chk("R10 group 7 at threshold", 64'(coinc_out[7]), 64'd1);
        chk("R10 group 7 local pick", 64'(pick_out[21]), 64'd1);
        chk("R10 other groups quiet", 64'(coinc_out & 16'hFF7E), 64'd0);

        // R9: reset in mid-run clears firing outputs.
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid-run reset", 64'(coinc_out), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule